// File: doc/BRIEF.md
# Byte-wide serial shift master with register access

This block lets a processor exchange single bytes with an external serial device over a four-wire synchronous link. The processor configures the link and starts each exchange through a small register bus with three locations. These are a control byte, a read-only status byte and a data byte. A write to the data location shifts the byte out on the output data line, most significant bit first. At the same time the block collects eight bits from the input data line. It generates the serial clock itself, with a selectable idle level, a selectable phase and one of four fixed rates.

When the eighth bit is finished, the received byte becomes readable at the data location and a completion flag is raised. The completion flag can also drive an interrupt line. A data write that arrives while a byte is still moving is refused and recorded in a collision flag; the byte in flight is not affected. A flag is only cleared by a two-step handshake. The processor first reads the status location while that flag is set, and then reads or writes the data location. An active-low reset aborts any exchange, zeroes the control byte and forgets a half-finished handshake.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, and also when reset is applied in the middle of a transfer, the control byte reads 0x00 and the status byte reads 0x00. The serial clock output is low, the interrupt output is low, and no serial clock edges follow until a new transfer is started.
- R2: Register address 0 is the control byte and reads back exactly what was last written. Its bits are bit 7 interrupt enable, bit 6 enable, bit 5 wired-or option (stored only), bit 4 master select (stored only), bit 3 clock polarity, bit 2 clock phase and bits 1:0 rate. Address 1 is status: bit 7 is transfer complete, bit 6 is collision, bit 4 is mode fault and always reads 0, and all other bits read 0. Address 2 is data.
- R3: Rate codes 0, 1, 2 and 3 give a serial clock half period of 1, 2, 8 and 16 system clocks, which is a full period of 2, 4, 16 and 32.
- R4: A data write while enable (control bit 6) is 0 starts nothing. No serial clock edge follows and no status flag is set.
- R5: A transfer makes exactly 16 serial clock edges and shifts the written byte out most significant bit first, one bit for every two edges.
- R6: While idle, the serial clock output equals the clock polarity bit (control bit 3).
- R7: With clock phase 0, the output data line carries bit 7 of the byte before the first serial clock edge. A receiver then samples on the odd-numbered edges (1st, 3rd, ...). With clock phase 1, a receiver samples on the even-numbered edges (2nd, 4th, ...).
- R8: The block samples the input data line on the same edges that a receiver uses per R7. After the transfer, a read of address 2 returns the eight sampled bits, the first sampled bit in bit 7.
- R9: When the last edge of a transfer is done, status bit 7 is set. The interrupt output is high exactly while control bit 7 and status bit 7 are both 1.
- R10: A data write while a transfer is running sets status bit 6. It neither restarts nor alters the transfer in flight.
- R11: A status flag is cleared only by a status read that sees it set, followed by a read or a write of address 2. A data access with no such status read before it leaves the flags unchanged.
- R12: Writes to address 1 have no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe, one cycle per access |
| rd_i | input | 1 | Register read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
A wrong bit or edge counter inside the shift engine shows up at the pins within one transfer. The external receiver model would count more or fewer than 16 clock edges, or would capture a byte that differs from the written one. It would also read back a received byte that is shifted or bit-swapped. A wrong divider count shows within a single half period of the serial clock, because the bench counts system clocks between two edges. Flag and handshake faults show on the next status read or on the interrupt pin, one cycle after the access that should have changed them.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned HALF_MAX = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       wired_or;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half period of the serial clock in system clocks
  function automatic int unsigned half_cycles(input logic [1:0] rate);
    case (rate)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/ssm_clk_div.sv
module ssm_clk_div
  import ssm_pkg::*;
#(
  parameter int unsigned HMAX = HALF_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned CW = (HMAX > 1) ? $clog2(HMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = CW'(half_cycles(rate_i) - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0) |=> (!tick_o || !$stable(rate_i)));
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter
  import ssm_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         cpha_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         mosi_o,
  output logic         phase_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int unsigned EDGES = 2 * W;
  localparam int unsigned EW    = $clog2(EDGES);

  logic [EW-1:0] edg_q;
  logic [W-1:0]  tx_q, rx_q;
  logic          busy_q, ph_q, done_q;
  logic          odd, sample_now, shift_now, last;

  assign odd        = edg_q[0];
  assign sample_now = cpha_i ? odd : !odd;
  // phase 1 presents bit 7 on the first edge without shifting
  assign shift_now  = cpha_i ? (!odd && edg_q != '0) : odd;
  assign last       = edg_q == EW'(EDGES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edg_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        tx_q   <= data_i;
        rx_q   <= '0;
        edg_q  <= '0;
        ph_q   <= 1'b0;
      end else if (busy_q && tick_i) begin
        ph_q  <= ~ph_q;
        edg_q <= last ? '0 : edg_q + 1'b1;
        if (sample_now) rx_q <= {rx_q[W-2:0], miso_i};
        if (shift_now)  tx_q <= {tx_q[W-2:0], 1'b0};
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign mosi_o  = tx_q[W-1];
  assign phase_o = ph_q;
  assign done_o  = done_q;
  assign rx_o    = rx_q;

  // R5
  edge_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (edg_q == '0));
  // R6
  phase_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !ph_q);
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       irq_o
);
  ctrl_t             ctrl_q;
  logic              done_q, wcol_q;
  logic [1:0]        arm_q;          // {done, wcol} seen by a status read
  logic [DATA_W-1:0] rxbuf_q;

  logic              busy, phase, tick, eng_done;
  logic [DATA_W-1:0] eng_rx;
  logic              sel_data, data_wr, data_acc, stat_rd, start, coll;

  assign sel_data = addr_i == REG_DATA;
  assign data_wr  = wr_i && sel_data;
  assign data_acc = (wr_i || rd_i) && sel_data;
  assign stat_rd  = rd_i && addr_i == REG_STAT;
  assign start    = data_wr && ctrl_q.enable && !busy;
  assign coll     = data_wr && ctrl_q.enable && busy;

  ssm_clk_div #(.HMAX(HALF_MAX)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .rate_i (ctrl_q.rate),
    .tick_o (tick)
  );

  ssm_shifter #(.W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (wdata_i),
    .cpha_i  (ctrl_q.cpha),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .mosi_o  (mosi_o),
    .phase_o (phase),
    .done_o  (eng_done),
    .rx_o    (eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      arm_q   <= '0;
      rxbuf_q <= '0;
    end else begin
      if (wr_i && addr_i == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i);
      if (stat_rd) arm_q <= {done_q, wcol_q};
      else if (data_acc) arm_q <= '0;
      done_q <= (done_q && !(data_acc && arm_q[1])) || eng_done;
      wcol_q <= (wcol_q && !(data_acc && arm_q[0])) || coll;
      if (eng_done) rxbuf_q <= eng_rx;
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {done_q, wcol_q, 6'b0};
      REG_DATA: rdata_o = rxbuf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign sck_o = ctrl_q.cpol ^ phase;
  assign irq_o = ctrl_q.irq_en && done_q;

  // R6
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sck_o == ctrl_q.cpol));
  // R10
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && ctrl_q.enable && busy) |=> (wcol_q && busy));
  // R9
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !busy);
  // R4
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !ctrl_q.enable && !busy) |=> !busy);
  // R11
  clear_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(data_acc));
endmodule

// File: tb/sim_sync_serial_master.sv
module sim_sync_serial_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, mosi, miso, irq;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;

  // receiver model
  bit         track = 0;
  bit         cur_cpha = 0;
  int         e = 0;
  logic [7:0] cap = '0;
  logic [7:0] slave_byte = '0;
  int         bidx;

  always #10 clk = ~clk;

  sync_serial_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .irq_o(irq)
  );

  always_comb begin
    if (cur_cpha) bidx = (e >= 1) ? (e - 1) / 2 : 0;
    else          bidx = e / 2;
    if (bidx > 7) bidx = 7;
  end
  assign miso = slave_byte[7 - bidx];

  always @(sck) begin
    if (track) begin
      if ((!cur_cpha && (e % 2 == 0)) || (cur_cpha && (e % 2 == 1)))
        cap = {cap[6:0], mosi};
      e = e + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic clear_flags();
    logic [7:0] d;
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    bus_rd(2'd0, d); chk(d == 8'h00, "R1", "ctrl after reset", d, 0);
    bus_rd(2'd1, d); chk(d == 8'h00, "R1", "status after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    bus_wr(2'd0, 8'h3A); // enable off
    bus_rd(2'd0, d); chk(d == 8'h3A, "R2", "ctrl readback", d, 8'h3A);
    bus_wr(2'd0, 8'h81);
    bus_rd(2'd0, d); chk(d == 8'h81, "R2", "ctrl readback 2", d, 8'h81);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, d); chk(d == 8'h00, "R12", "status after write", d, 0);
    bus_wr(2'd0, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    bus_wr(2'd0, 8'h80); // irq enable, system disabled
    e = 0; track = 1;
    bus_wr(2'd2, 8'h55);
    repeat (40) @(negedge clk);
    track = 0;
    chk(e == 0, "R4", "edges when disabled", e, 0);
    bus_rd(2'd1, d); chk(d == 8'h00, "R4", "status when disabled", d, 0);
    chk(irq == 1'b0, "R4", "irq when disabled", irq, 0);
  endtask

  task automatic t_xfer(input bit cpol, input bit cpha, input logic [1:0] rate,
                        input logic [7:0] tx, input logic [7:0] rxv);
    logic [7:0] d;
    int h;
    h = half_of(rate);
    bus_wr(2'd0, {1'b1, 1'b1, 2'b00, cpol, cpha, rate});
    chk(sck == cpol, "R6", "idle sck level", sck, cpol);
    cur_cpha = cpha; slave_byte = rxv; e = 0; cap = '0; track = 1;
    bus_wr(2'd2, tx);
    if (!cpha) begin
      chk(mosi == tx[7], "R7", "first bit before first edge", mosi, tx[7]);
      chk(sck == cpol, "R7", "no edge yet at start", sck, cpol);
    end
    repeat (16 * h + 4) @(negedge clk);
    track = 0;
    chk(e == 16, "R5", "edge count", e, 16);
    chk(cap == tx, "R5", "bits seen by receiver", cap, tx);
    chk(sck == cpol, "R6", "sck back to idle", sck, cpol);
    chk(irq == 1'b1, "R9", "irq at completion", irq, 1);
    bus_rd(2'd1, d); chk(d == 8'h80, "R9", "status at completion", d, 8'h80);
    bus_rd(2'd2, d); chk(d == rxv, "R8", "received byte", d, rxv);
    bus_rd(2'd1, d); chk(d == 8'h00, "R11", "status after handshake", d, 0);
    chk(irq == 1'b0, "R9", "irq after clear", irq, 0);
  endtask

  task automatic t_rate(input logic [1:0] rate);
    logic p;
    int n;
    bus_wr(2'd0, {4'b0100, 2'b00, rate});
    bus_wr(2'd2, 8'hC5);
    n = 0;
    p = sck;
    while (sck == p && n < 100) begin @(negedge clk); n++; end
    p = sck; n = 0;
    do begin @(negedge clk); n++; end while (sck == p && n < 100);
    chk(n == half_of(rate), "R3", "half period", n, half_of(rate));
    repeat (16 * half_of(rate) + 4) @(negedge clk);
    clear_flags();
  endtask

  task automatic t_wcol();
    logic [7:0] d;
    bus_wr(2'd0, 8'h42); // enable, rate 2
    cur_cpha = 0; slave_byte = 8'h5A; e = 0; cap = '0; track = 1;
    bus_wr(2'd2, 8'hE1);
    repeat (10) @(negedge clk);
    bus_wr(2'd2, 8'h0F);
    bus_rd(2'd1, d); chk(d == 8'h40, "R10", "collision flag mid transfer", d, 8'h40);
    repeat (16 * 8 + 4) @(negedge clk);
    track = 0;
    chk(e == 16, "R10", "edges not restarted", e, 16);
    chk(cap == 8'hE1, "R10", "byte in flight unchanged", cap, 8'hE1);
    bus_rd(2'd1, d); chk(d == 8'hC0, "R10", "status both flags", d, 8'hC0);
    bus_rd(2'd2, d); chk(d == 8'h5A, "R8", "received byte after collision", d, 8'h5A);
    bus_rd(2'd1, d); chk(d == 8'h00, "R11", "both flags cleared", d, 0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    bus_wr(2'd0, 8'hC0);
    cur_cpha = 0; slave_byte = 8'h00;
    bus_wr(2'd2, 8'h33);
    repeat (16 + 4) @(negedge clk);
    bus_rd(2'd2, d); // no status read before
    chk(irq == 1'b1, "R11", "irq kept without status read", irq, 1);
    bus_rd(2'd1, d); chk(d == 8'h80, "R11", "flag kept without status read", d, 8'h80);
    bus_wr(2'd0, 8'h80); // disable so the data write starts nothing
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd1, d); chk(d == 8'h00, "R11", "cleared by data write", d, 0);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    bus_wr(2'd0, 8'h4B); // cpol 1, rate 3
    bus_wr(2'd2, 8'hAA);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sck == 1'b0, "R1", "sck on reset mid transfer", sck, 0);
    chk(irq == 1'b0, "R1", "irq on reset mid transfer", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    e = 0; track = 1;
    repeat (600) @(negedge clk);
    track = 0;
    chk(e == 0, "R1", "no edges after abort", e, 0);
    bus_rd(2'd0, d); chk(d == 8'h00, "R1", "ctrl after abort", d, 0);
    bus_rd(2'd1, d); chk(d == 8'h00, "R1", "status after abort", d, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_disabled();
    t_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C);
    t_xfer(1'b0, 1'b1, 2'd1, 8'h96, 8'hC3);
    t_xfer(1'b1, 1'b0, 2'd0, 8'h01, 8'h80);
    t_xfer(1'b1, 1'b1, 2'd3, 8'h7E, 8'h81);
    for (int r = 0; r < 4; r++) t_rate(2'(r));
    t_wcol();
    t_clear();
    t_reset_mid();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule